// File: doc/BRIEF.md
# Stop-Bit Field Decompressor

This block turns a byte stream of variable-length, stop-bit encoded integer fields into fixed-size words. Each input byte carries seven payload bits in its low bits; its top bit marks the final byte of a field. The block strips that flag, joins the 7-bit groups with the earliest byte as the most significant group, and presents the field right-aligned in a 64-bit word. Later stages can then treat every field as one word.

Fields carry no length prefix and no framing. A short value may arrive as a single byte because leading all-zero groups are omitted. One packet may hold many fields back to back. The block flags a field that is too long or too large to fit 64 bits and still emits it. It also flushes a field that the end of a packet cuts short, and marks it as truncated. The input and output both use valid/ready handshakes, and the end-of-packet marker travels with the data.

Top module: `sbit_unpacker`

## Requirements
- R1: After reset is released, `out_valid` is low and `in_ready` is high.
- R2: An accepted byte with bit 7 set and no field in progress emits a word equal to its bits 6:0, zero-extended (0x81 gives 0x1, 0xFF gives 0x7F).
- R3: A multi-byte field emits its 7-bit groups joined, with the first received group most significant (0x2A then 0xBF gives 0x153F).
- R4: A field of at most 10 bytes whose value fits 64 bits is emitted with `out_ovf` low, including the value 2^64-1 (0x01, eight 0x7F, 0xFF).
- R5: A field of more than 10 bytes, or one whose joined value needs more than 64 bits, is emitted with `out_ovf` high and with the low 64 bits of the joined value as its word.
- R6: A field whose stop byte is accepted with `in_last` high is emitted with `out_last` high and `out_trunc` low. Any other completed field has both low.
- R7: A byte without a stop flag, accepted with `in_last` high, emits the partial value with `out_trunc` and `out_last` high. The next byte starts a new field.
- R8: While `out_valid` is high and `out_ready` is low, the output word and flags hold, `in_ready` is low, and no field is lost.
- R9: With `out_ready` held high, the block accepts one byte every cycle.
- R10: Cycles with `in_valid` low leave a field in progress and the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Encoded byte: bit 7 is the stop flag, bits 6:0 are the payload group |
| in_valid | input | 1 | `in_byte` is valid |
| in_last | input | 1 | Byte is the last one of its packet |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_word | output | 64 | Decoded field, right-aligned |
| out_ovf | output | 1 | Field was too long or too large |
| out_trunc | output | 1 | Field was cut short by end of packet |
| out_last | output | 1 | Field closes the packet |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer takes the word this cycle |

## Verification
Two of the block's functions can fall in one edge: the output register drains a word while a new stop byte loads the next one, and a truncating end of packet lands on a field that has already overflowed. The first is provoked by back-to-back single-byte fields under full and pseudo-random `out_ready`. A scoreboard judges it: each field must appear exactly once and in order. The second is provoked by eleven 0x7F bytes, the last of which carries `in_last` without a stop flag. That word must show `out_ovf`, `out_trunc` and `out_last` together, with the low 64 bits of the joined value.

// File: rtl/sbit_pkg.sv
package sbit_pkg;
  // number of payload groups needed to cover a word of the given width
  function automatic int groups_for(input int word_w, input int group_w);
    return (word_w + group_w - 1) / group_w;
  endfunction
endpackage

// File: rtl/sbit_accum.sv
module sbit_accum #(
  parameter int WORD_W    = 64,
  parameter int GROUP_W   = 7,
  parameter int MAX_BYTES = 10,
  localparam int CNT_W    = $clog2(MAX_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [GROUP_W:0]  byte_in,
  input  logic              last_in,
  output logic              emit,
  output logic [WORD_W-1:0] emit_word,
  output logic              emit_ovf,
  output logic              emit_trunc,
  output logic              emit_last
);
  logic [WORD_W-1:0] acc_q, acc_d, joined;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              stop, lost, too_long, ovf_now;

  always_comb begin
    stop     = byte_in[GROUP_W];
    joined   = {acc_q[WORD_W-GROUP_W-1:0], byte_in[GROUP_W-1:0]};
    lost     = |acc_q[WORD_W-1:WORD_W-GROUP_W];
    too_long = (cnt_q >= CNT_W'(MAX_BYTES));
    ovf_now  = ovf_q | lost | too_long;
    emit       = take & (stop | last_in);
    emit_word  = joined;
    emit_ovf   = ovf_now;
    emit_trunc = last_in & ~stop;
    emit_last  = last_in;
    acc_d = acc_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (take) begin
      if (emit) begin
        acc_d = '0;
        cnt_d = '0;
        ovf_d = 1'b0;
      end else begin
        acc_d = joined;
        cnt_d = too_long ? cnt_q : cnt_q + 1'b1;
        ovf_d = ovf_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (take) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/sbit_outreg.sv
module sbit_outreg #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ovf_in,
  input  logic              trunc_in,
  input  logic              last_in,
  input  logic              drain,
  output logic              room,
  output logic              valid_q,
  output logic [WORD_W-1:0] word_q,
  output logic              ovf_q,
  output logic              trunc_q,
  output logic              last_q
);
  logic valid_d;

  always_comb begin
    room    = ~valid_q | drain;
    valid_d = valid_q;
    if (load)       valid_d = 1'b1;
    else if (drain) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ovf_q   <= 1'b0;
      trunc_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (load) begin
      word_q  <= word_in;
      ovf_q   <= ovf_in;
      trunc_q <= trunc_in;
      last_q  <= last_in;
    end
  end
endmodule

// File: rtl/sbit_unpacker.sv
module sbit_unpacker #(
  parameter int WORD_W  = 64,
  parameter int GROUP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUP_W:0]  in_byte,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_ovf,
  output logic              out_trunc,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int MAX_BYTES = sbit_pkg::groups_for(WORD_W, GROUP_W);

  logic              take, emit, e_ovf, e_trunc, e_last, room;
  logic [WORD_W-1:0] e_word;

  assign take     = in_valid & room;
  assign in_ready = room;

  sbit_accum #(.WORD_W(WORD_W), .GROUP_W(GROUP_W), .MAX_BYTES(MAX_BYTES)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_byte), .last_in(in_last),
    .emit(emit), .emit_word(e_word), .emit_ovf(e_ovf), .emit_trunc(e_trunc),
    .emit_last(e_last)
  );

  sbit_outreg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .word_in(e_word), .ovf_in(e_ovf),
    .trunc_in(e_trunc), .last_in(e_last), .drain(out_ready), .room(room),
    .valid_q(out_valid), .word_q(out_word), .ovf_q(out_ovf), .trunc_q(out_trunc),
    .last_q(out_last)
  );
endmodule

// File: rtl/sbit_unpacker_chk.sv
module sbit_unpacker_chk #(
  parameter int WORD_W  = 64,
  parameter int GROUP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GROUP_W:0]  in_byte,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_ovf,
  input logic              out_trunc,
  input logic              out_last,
  input logic              out_valid,
  input logic              out_ready
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ovf)
                                && $stable(out_trunc) && $stable(out_last));
  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r2_stop_emits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_byte[GROUP_W] |=> out_valid);
  a_r6_last_marked: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> out_valid && out_last);
  a_r7_trunc_has_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trunc |-> out_last);
  a_r9_ready_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !out_ready |=> $stable(out_valid));
endmodule

bind sbit_unpacker sbit_unpacker_chk #(.WORD_W(WORD_W), .GROUP_W(GROUP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .out_word(out_word), .out_ovf(out_ovf), .out_trunc(out_trunc),
  .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/tb_sbit_unpacker.sv
module tb_sbit_unpacker;
  typedef struct packed {
    logic [63:0] w;
    logic        ovf;
    logic        trunc;
    logic        last;
  } exp_t;

  logic        clk, rst_n;
  logic [7:0]  in_byte;
  logic        in_valid, in_last, in_ready;
  logic [63:0] out_word;
  logic        out_ovf, out_trunc, out_last, out_valid, out_ready;

  int checks = 0, failures = 0, cyc = 0, rmode = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t  expq[$];
  string reqq[$];
  logic [127:0] m_acc = '0;
  int m_cnt = 0;

  sbit_unpacker dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .out_word(out_word), .out_ovf(out_ovf), .out_trunc(out_trunc),
    .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready)
  );

  initial clk = 0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ready driver: 0 = always, 1 = pseudo-random, 2 = stalled
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(0, "R8", "unexpected word", out_word, 64'h0);
      end else begin
        exp_t e;
        string r;
        e = expq.pop_front();
        r = reqq.pop_front();
        check(out_word == e.w, r, "word", out_word, e.w);
        check({out_ovf, out_trunc, out_last} == {e.ovf, e.trunc, e.last}, r,
              "flags ovf/trunc/last", {61'b0, out_ovf, out_trunc, out_last},
              {61'b0, e.ovf, e.trunc, e.last});
      end
    end
  end

  // driver: called at posedge+1
  task automatic send(input logic [7:0] b, input logic last, input string req);
    in_byte = b; in_last = last; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    m_acc = (m_acc << 7) | {121'b0, b[6:0]};
    m_cnt++;
    if (b[7] || last) begin
      exp_t e;
      e.w = m_acc[63:0];
      e.ovf = (m_cnt > 10) || (m_acc[127:64] != 0);
      e.trunc = last && !b[7];
      e.last = last;
      expq.push_back(e);
      reqq.push_back(req);
      m_acc = '0;
      m_cnt = 0;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || out_valid) && n < 2000) begin
      @(posedge clk); #1; n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0;
    rst_n = 0; in_byte = 0; in_valid = 0; in_last = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", {63'b0, out_valid}, 64'h0);
    check(in_ready == 1, "R1", "in_ready after reset", {63'b0, in_ready}, 64'h1);
    @(posedge clk); #1;
    // R2 single bytes
    send(8'h81, 0, "R2"); send(8'h80, 0, "R2"); send(8'hFF, 0, "R2");
    // R3 multi-byte
    send(8'h2A, 0, "R3"); send(8'hBF, 0, "R3");
    send(8'h03, 0, "R3"); send(8'h00, 0, "R3"); send(8'h81, 0, "R3");
    // R4 full 64-bit value
    send(8'h01, 0, "R4");
    for (int i = 0; i < 8; i++) send(8'h7F, 0, "R4");
    send(8'hFF, 0, "R4");
    // R5 value too large, then too many bytes
    send(8'h02, 0, "R5");
    for (int i = 0; i < 8; i++) send(8'h7F, 0, "R5");
    send(8'hFF, 0, "R5");
    for (int i = 0; i < 10; i++) send(8'h00, 0, "R5");
    send(8'h81, 0, "R5");
    // R6 end of packet on stop byte
    send(8'h85, 1, "R6");
    // R7 truncated field, then fresh field
    send(8'h2A, 0, "R7"); send(8'h15, 1, "R7"); send(8'h81, 0, "R7");
    // overflow and truncation together
    for (int i = 0; i < 10; i++) send(8'h7F, 0, "R5_R7");
    send(8'h7F, 1, "R5_R7");
    drain();
    // R10 idle mid-field
    send(8'h2A, 0, "R10");
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R10", "out_valid during idle", {63'b0, out_valid}, 64'h0);
    @(posedge clk); #1;
    send(8'hBF, 0, "R10");
    drain();
    // R9 throughput
    c0 = cyc;
    for (int i = 0; i < 4; i++) send(8'h90 + 8'(i), 0, "R9");
    check(cyc - c0 == 4, "R9", "cycles for 4 bytes", 64'(cyc - c0), 64'd4);
    drain();
    // R8 stall
    rmode = 2;
    @(posedge clk); #1;
    send(8'h85, 0, "R8");
    repeat (3) @(negedge clk);
    check(out_valid == 1, "R8", "held valid", {63'b0, out_valid}, 64'h1);
    check(in_ready == 0, "R8", "in_ready while full", {63'b0, in_ready}, 64'h0);
    check(out_word == 64'h5, "R8", "held word", out_word, 64'h5);
    rmode = 1;
    for (int k = 0; k < 20; k++) begin
      send(8'h10 + 8'(k), 0, "R8");
      send(8'h80 + 8'(k), (k % 3) == 0, "R8");
    end
    rmode = 0;
    drain();
    check(expq.size() == 0, "R8", "items left", 64'(expq.size()), 64'h0);
    finish_run();
  end
endmodule